// File: doc/BRIEF.md
# Multiplexed-Bus Flash Front End

This block models the device-side front end of a 16-bit flash memory whose address and data share one bus. A rising edge on the address-latch strobe captures a 16-bit address from the bus. The block then works out the bus operation from chip enable, output enable, write enable, a reset/power-down pin and a write-protect pin. It either drives read data onto the bus or leaves the bus released. The bus is modelled as an input word, an output word and an output-enable flag, so `adq_oe_o` low stands for high impedance.

Array reads go through a four-word page buffer. The page is filled from a computed array image when the latched address moves to a new page. Written command words switch the block between array reads and an identifier mode. In identifier mode the block returns a manufacturer code, a device code and the status of each block. Each block keeps a protected flag and a locked flag in registers. Commands set and clear these flags. Clearing protection on a locked block depends on the write-protect pin.

All pins are sampled on `clk`. Read data and the output enable appear one clock after the pin levels that request them.

Top module: `mxflash_front`

## Requirements
- R1: On a clock where `latch_i` is high and was low on the previous clock, the word on `adq_i` becomes the current address. While the strobe stays high or stays low, the address does not change.
- R2: In array mode a read returns `(A * PAT_MUL) ^ PAT_XOR`, truncated to 16 bits, where A is the full 16-bit latched address. Bits 1:0 of A pick the word inside the four-word page.
- R3: `adq_oe_o` is high, and `adq_o` carries read data, only one clock after a clock where `ce_ni`=0, `oe_ni`=0 and `pd_ni`=1 were sampled. Standby (`ce_ni`=1) and write or idle cycles (`oe_ni`=1) leave the bus released.
- R4: While `pd_ni` is low the bus is released regardless of the other pins. The block returns to array mode, and every block comes back protected and unlocked (status 0001h). The same state follows `rst_ni`.
- R5: A command is taken once per falling edge of `we_ni` while `ce_ni`=0, `oe_ni`=1 and `pd_ni`=1. The command word is the full 16-bit bus value. Word 0090h enters identifier mode and word 00FFh returns to array mode.
- R6: In identifier mode, low address byte 00h reads 0020h. Low byte 01h reads 00A4h when VARIANT=0 and 00A5h when VARIANT=1. Address bits 15:8 are ignored for these two offsets.
- R7: In identifier mode, low byte 02h reads the status of the block selected by the top log2(BLOCKS) address bits: bit 0 is protected and bit 1 is locked, so the values are 0000h to 0003h. Any other low byte reads 0000h.
- R8: Command 0041h sets the protected flag of the block addressed by the latched address. Command 0043h sets its locked flag. Only power-down or reset clears a locked flag.
- R9: Command 0042h clears the protected flag if the block is unlocked or `wp_ni` is high. If the block is locked and `wp_ni` is low, the command has no effect.
- R10: A write pulse whose falling edge lands on a clock where `pd_ni` is low is discarded. The reset state of R4 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which all pins are sampled |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| latch_i | input | 1 | Address-latch strobe; rising edge captures the bus |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| pd_ni | input | 1 | Reset/power-down pin, active low |
| wp_ni | input | 1 | Write-protect pin; high permits unprotecting locked blocks |
| adq_i | input | 16 | Shared address/data bus, value seen by the device |
| adq_o | output | 16 | Read data driven onto the shared bus |
| adq_oe_o | output | 1 | High when the device drives the bus; low means high impedance |

## Verification
A command write and a power-down can land on the same clock. In that case the reset of all block flags and the mode must win over the command. The bench provokes this by lowering `pd_ni` on the very clock where `we_ni` falls with an unprotect or identifier command on the bus. It then reads back the block status and the mode through normal reads: the status must be 0001h and reads must return array data. Random traffic also mixes power-down pulses with protect, lock and write-protect changes, and a bench model of every block's flags judges each status read.

// File: rtl/mxflash_pkg.sv
package mxflash_pkg;

  localparam int unsigned DW        = 16;
  localparam int unsigned PAGE_W    = 4;
  localparam int unsigned PAGE_SELW = 2;

  localparam logic [DW-1:0] CMD_IDENT  = 16'h0090;
  localparam logic [DW-1:0] CMD_ARRAY  = 16'h00FF;
  localparam logic [DW-1:0] CMD_PROT   = 16'h0041;
  localparam logic [DW-1:0] CMD_UNPROT = 16'h0042;
  localparam logic [DW-1:0] CMD_LOCK   = 16'h0043;

  localparam logic [DW-1:0] MFR_CODE   = 16'h0020;

  typedef enum logic {
    MODE_ARRAY = 1'b0,
    MODE_IDENT = 1'b1
  } mode_e;

  // Computed array image: one word per 16-bit address.
  function automatic logic [DW-1:0] array_word(input logic [DW-1:0] a,
                                               input logic [DW-1:0] mul,
                                               input logic [DW-1:0] xr);
    logic [DW-1:0] prod;
    prod = a * mul;
    return prod ^ xr;
  endfunction

endpackage

// File: rtl/mxflash_latch.sv
module mxflash_latch
  import mxflash_pkg::*;
#(
  parameter logic [DW-1:0] PAT_MUL = 16'h9E37,
  parameter logic [DW-1:0] PAT_XOR = 16'h5A5A
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pd_n,
  input  logic                        latch,
  input  logic [DW-1:0]               bus_in,
  output logic [DW-1:0]               addr_q,
  output logic [PAGE_W-1:0][DW-1:0]   page_q
);

  localparam int unsigned BASE_W = DW - PAGE_SELW;

  logic              latch_q;
  logic              page_vld_q;
  logic [BASE_W-1:0] base_q;

  logic              rise;
  logic              fill;
  logic              page_vld_nxt;
  logic [BASE_W-1:0] new_base;

  assign new_base = bus_in[DW-1:PAGE_SELW];
  assign rise     = latch & ~latch_q;
  assign fill     = rise & (~page_vld_q | (base_q != new_base));

  always_comb begin
    page_vld_nxt = page_vld_q;
    if (!pd_n)     page_vld_nxt = 1'b0;
    else if (fill) page_vld_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= 1'b0;
      page_vld_q <= 1'b0;
      addr_q     <= '0;
      base_q     <= '0;
    end else begin
      latch_q    <= latch;
      page_vld_q <= page_vld_nxt;
      if (rise) addr_q <= bus_in;
      if (fill) base_q <= new_base;
    end
  end

  // One register per page word, refilled only on a page change.
  for (genvar w = 0; w < PAGE_W; w++) begin : g_page
    logic [DW-1:0] word_nxt;
    assign word_nxt = array_word({new_base, PAGE_SELW'(w)}, PAT_MUL, PAT_XOR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    page_q[w] <= '0;
      else if (fill) page_q[w] <= word_nxt;
    end
  end

endmodule

// File: rtl/mxflash_cmd.sv
module mxflash_cmd
  import mxflash_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] bus_in,
  output logic          cmd_vld,
  output logic [DW-1:0] cmd_word,
  output mode_e         mode_q
);

  logic  we_q;
  mode_e mode_nxt;

  assign cmd_vld  = pd_n & ~ce_n & oe_n & ~we_n & we_q;
  assign cmd_word = bus_in;

  always_comb begin
    mode_nxt = mode_q;
    if (!pd_n) begin
      mode_nxt = MODE_ARRAY;
    end else if (cmd_vld) begin
      if (cmd_word == CMD_IDENT)      mode_nxt = MODE_IDENT;
      else if (cmd_word == CMD_ARRAY) mode_nxt = MODE_ARRAY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      mode_q <= MODE_ARRAY;
    end else begin
      we_q   <= we_n;
      mode_q <= mode_nxt;
    end
  end

endmodule

// File: rtl/mxflash_blkstat.sv
module mxflash_blkstat
  import mxflash_pkg::*;
#(
  parameter int unsigned BLOCKS = 8,
  localparam int unsigned BW    = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              wp_n,
  input  logic              cmd_vld,
  input  logic [DW-1:0]     cmd_word,
  input  logic [BW-1:0]     blk_sel,
  output logic [BLOCKS-1:0] prot_vec,
  output logic [BLOCKS-1:0] lock_vec
);

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    logic hit;
    logic prot_nxt;
    logic lock_nxt;

    assign hit = cmd_vld & (blk_sel == BW'(b));

    always_comb begin
      prot_nxt = prot_vec[b];
      lock_nxt = lock_vec[b];
      if (!pd_n) begin
        prot_nxt = 1'b1;
        lock_nxt = 1'b0;
      end else if (hit) begin
        case (cmd_word)
          CMD_PROT:   prot_nxt = 1'b1;
          CMD_LOCK:   lock_nxt = 1'b1;
          CMD_UNPROT: if (!lock_vec[b] || wp_n) prot_nxt = 1'b0;
          default:    ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prot_vec[b] <= 1'b1;
        lock_vec[b] <= 1'b0;
      end else begin
        prot_vec[b] <= prot_nxt;
        lock_vec[b] <= lock_nxt;
      end
    end
  end

endmodule

// File: rtl/mxflash_front.sv
module mxflash_front
  import mxflash_pkg::*;
#(
  parameter int unsigned   BLOCKS  = 8,
  parameter int unsigned   VARIANT = 0,
  parameter logic [15:0]   PAT_MUL = 16'h9E37,
  parameter logic [15:0]   PAT_XOR = 16'h5A5A
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        latch_i,
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic        we_ni,
  input  logic        pd_ni,
  input  logic        wp_ni,
  input  logic [15:0] adq_i,
  output logic [15:0] adq_o,
  output logic        adq_oe_o
);

  localparam int unsigned   BW       = $clog2(BLOCKS);
  localparam logic [DW-1:0] DEV_CODE = (VARIANT == 0) ? 16'h00A4 : 16'h00A5;

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [DW-1:0]             addr_q;
  logic [PAGE_W-1:0][DW-1:0] page_q;
  logic                      cmd_vld;
  logic [DW-1:0]             cmd_word;
  mode_e                     mode_q;
  logic                      ident_mode;
  logic [BLOCKS-1:0]         prot_vec;
  logic [BLOCKS-1:0]         lock_vec;
  logic [BW-1:0]             blk_sel;

  assign blk_sel    = addr_q[DW-1 -: BW];
  assign ident_mode = (mode_q == MODE_IDENT);

  mxflash_latch #(
    .PAT_MUL (PAT_MUL),
    .PAT_XOR (PAT_XOR)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pd_n   (pd_ni),
    .latch  (latch_i),
    .bus_in (adq_i),
    .addr_q (addr_q),
    .page_q (page_q)
  );

  mxflash_cmd u_cmd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pd_n     (pd_ni),
    .ce_n     (ce_ni),
    .oe_n     (oe_ni),
    .we_n     (we_ni),
    .bus_in   (adq_i),
    .cmd_vld  (cmd_vld),
    .cmd_word (cmd_word),
    .mode_q   (mode_q)
  );

  mxflash_blkstat #(
    .BLOCKS (BLOCKS)
  ) u_blk (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pd_n     (pd_ni),
    .wp_n     (wp_ni),
    .cmd_vld  (cmd_vld),
    .cmd_word (cmd_word),
    .blk_sel  (blk_sel),
    .prot_vec (prot_vec),
    .lock_vec (lock_vec)
  );

  // Read data selection
  logic [DW-1:0] rd_data;
  logic          drive_nxt;

  always_comb begin
    if (ident_mode) begin
      case (addr_q[7:0])
        8'h00:   rd_data = MFR_CODE;
        8'h01:   rd_data = DEV_CODE;
        8'h02:   rd_data = {14'b0, lock_vec[blk_sel], prot_vec[blk_sel]};
        default: rd_data = '0;
      endcase
    end else begin
      rd_data = page_q[addr_q[PAGE_SELW-1:0]];
    end
  end

  assign drive_nxt = pd_ni & ~ce_ni & ~oe_ni;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      adq_oe_o <= 1'b0;
      adq_o    <= '0;
    end else begin
      adq_oe_o <= drive_nxt;
      if (drive_nxt) adq_o <= rd_data;
    end
  end

endmodule

// File: rtl/mxflash_front_chk.sv
module mxflash_front_chk #(
  parameter int unsigned BLOCKS = 8
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              latch_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              pd_ni,
  input logic              wp_ni,
  input logic [15:0]       adq_i,
  input logic              adq_oe_o,
  input logic [15:0]       addr_q,
  input logic [BLOCKS-1:0] prot_vec,
  input logic [BLOCKS-1:0] lock_vec,
  input logic              ident_mode
);

  p_addr_capture_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (latch_i && !$past(latch_i)) |=> (addr_q == $past(adq_i)));

  p_drive_gate_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    adq_oe_o |-> $past(!ce_ni && !oe_ni && pd_ni));

  p_hiz_pd_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(pd_ni) |-> !adq_oe_o);

  p_pd_defaults_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(pd_ni) |-> ((&prot_vec) && (lock_vec == '0) && !ident_mode));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(pd_ni) |-> (($past(lock_vec) & ~lock_vec) == '0));

  p_wp_gate_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(pd_ni) && !$past(wp_ni)) |-> (($past(prot_vec & lock_vec) & ~prot_vec) == '0));

endmodule

bind mxflash_front mxflash_front_chk #(
  .BLOCKS (BLOCKS)
) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .latch_i    (latch_i),
  .ce_ni      (ce_ni),
  .oe_ni      (oe_ni),
  .pd_ni      (pd_ni),
  .wp_ni      (wp_ni),
  .adq_i      (adq_i),
  .adq_oe_o   (adq_oe_o),
  .addr_q     (addr_q),
  .prot_vec   (prot_vec),
  .lock_vec   (lock_vec),
  .ident_mode (ident_mode)
);

// File: tb/mxflash_front_test.sv
module mxflash_front_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          NBLK       = 8;
  localparam logic [15:0] MUL        = 16'h9E37;
  localparam logic [15:0] XR         = 16'h5A5A;
  localparam logic [15:0] DEVC       = 16'h00A4;

  logic        clk = 1'b0;
  logic        rst_ni, latch_i, ce_ni, oe_ni, we_ni, pd_ni, wp_ni;
  logic [15:0] adq_i;
  logic [15:0] adq_o;
  logic        adq_oe_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  bit            m_prot [NBLK];
  bit            m_lock [NBLK];
  bit            m_ident;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxflash_front #(
    .BLOCKS (NBLK), .VARIANT (0), .PAT_MUL (MUL), .PAT_XOR (XR)
  ) uut (
    .clk (clk), .rst_ni (rst_ni), .latch_i (latch_i), .ce_ni (ce_ni),
    .oe_ni (oe_ni), .we_ni (we_ni), .pd_ni (pd_ni), .wp_ni (wp_ni),
    .adq_i (adq_i), .adq_o (adq_o), .adq_oe_o (adq_oe_o)
  );

  function automatic logic [15:0] exp_array(input logic [15:0] a);
    logic [15:0] p;
    p = a * MUL;
    return p ^ XR;
  endfunction

  function automatic logic [15:0] exp_ident(input logic [15:0] a);
    logic [2:0] b;
    b = a[15:13];
    case (a[7:0])
      8'h00:   return 16'h0020;
      8'h01:   return DEVC;
      8'h02:   return {14'b0, m_lock[b], m_prot[b]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic model_pd();
    for (int b = 0; b < NBLK; b++) begin
      m_prot[b] = 1'b1;
      m_lock[b] = 1'b0;
    end
    m_ident = 1'b0;
  endtask

  task automatic model_cmd(input logic [15:0] a, input logic [15:0] c);
    logic [2:0] b;
    b = a[15:13];
    case (c)
      16'h0090: m_ident = 1'b1;
      16'h00FF: m_ident = 1'b0;
      16'h0041: m_prot[b] = 1'b1;
      16'h0043: m_lock[b] = 1'b1;
      16'h0042: if (!m_lock[b] || wp_ni) m_prot[b] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic idle();
    latch_i = 1'b0; ce_ni = 1'b1; oe_ni = 1'b1; we_ni = 1'b1;
  endtask

  task automatic latch_addr(input logic [15:0] a);
    @(negedge clk);
    adq_i = a; latch_i = 1'b1;
    @(negedge clk);
    latch_i = 1'b0;
  endtask

  // Write pulse; with pd_low the power-down pin falls on the same clock.
  task automatic write_cmd(input logic [15:0] a, input logic [15:0] c, input bit pd_low);
    latch_addr(a);
    ce_ni = 1'b0; oe_ni = 1'b1; we_ni = 1'b0; adq_i = c;
    if (pd_low) pd_ni = 1'b0;
    @(negedge clk);
    we_ni = 1'b1; ce_ni = 1'b1; pd_ni = 1'b1;
    if (pd_low) model_pd();
    else        model_cmd(a, c);
  endtask

  task automatic read_cur(output logic [16:0] r);
    ce_ni = 1'b0; oe_ni = 1'b0;
    @(negedge clk);
    r = {adq_oe_o, adq_o};
    ce_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic read_at(input logic [15:0] a, output logic [16:0] r);
    latch_addr(a);
    read_cur(r);
  endtask

  task automatic chk_read(input string req, input logic [15:0] a);
    logic [16:0] r;
    read_at(a, r);
    check(req, r, {1'b1, m_ident ? exp_ident(a) : exp_array(a)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [16:0] r;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_ni = 1'b0; pd_ni = 1'b1; wp_ni = 1'b0; adq_i = '0;
    idle();
    model_pd();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R4: reset state, bus released
    check("R4 reset oe", {16'h0, adq_oe_o}, 17'h0);

    // R2: words across a page boundary and wrap of the index
    for (int i = 0; i < 8; i++) chk_read("R2 page walk", 16'(i));
    chk_read("R2 top word", 16'hFFFF);
    chk_read("R2 high bits", 16'hE003);
    chk_read("R2 same page other word", 16'hE001);

    // R3: standby and non-read cycles leave the bus released
    ce_ni = 1'b1; oe_ni = 1'b0;
    @(negedge clk);
    check("R3 standby", {16'h0, adq_oe_o}, 17'h0);
    ce_ni = 1'b0; oe_ni = 1'b1;
    @(negedge clk);
    check("R3 output disable", {16'h0, adq_oe_o}, 17'h0);
    idle();

    // R1: strobe held high does not recapture
    @(negedge clk);
    adq_i = 16'h1234; latch_i = 1'b1;
    @(negedge clk);
    adq_i = 16'h4321;
    @(negedge clk);
    latch_i = 1'b0; adq_i = 16'hBEEF;
    @(negedge clk);
    read_cur(r);
    check("R1 hold while high", r, {1'b1, exp_array(16'h1234)});

    // R5, R6, R7: identifier mode
    write_cmd(16'h0000, 16'h0090, 1'b0);
    chk_read("R6 manufacturer", 16'h1F00);
    chk_read("R6 device", 16'hA501);
    chk_read("R7 status reset", 16'h4002);
    chk_read("R7 other offset", 16'h4003);

    // R8, R9: flag matrix on block 2
    wp_ni = 1'b0;
    write_cmd(16'h4000, 16'h0042, 1'b0);
    chk_read("R9 unprotect unlocked", 16'h4002);
    write_cmd(16'h4000, 16'h0043, 1'b0);
    chk_read("R8 lock", 16'h4002);
    write_cmd(16'h4000, 16'h0041, 1'b0);
    chk_read("R8 protect", 16'h4002);
    write_cmd(16'h4000, 16'h0042, 1'b0);
    chk_read("R9 wp low blocks unprotect", 16'h4002);
    wp_ni = 1'b1;
    write_cmd(16'h4000, 16'h0042, 1'b0);
    chk_read("R9 wp high allows unprotect", 16'h4002);
    chk_read("R7 neighbour block", 16'h6002);

    // R5: return to array
    write_cmd(16'h0000, 16'h00FF, 1'b0);
    chk_read("R5 array again", 16'h0123);

    // R10: power-down on the same clock as a command
    write_cmd(16'h0000, 16'h0090, 1'b0);
    write_cmd(16'hA000, 16'h0042, 1'b1);
    chk_read("R10 command dropped, array mode", 16'hA002);
    write_cmd(16'h0000, 16'h0090, 1'b0);
    chk_read("R10 status after pd", 16'hA002);
    chk_read("R4 lock cleared", 16'h4002);

    // R4: power-down releases the bus with a read requested
    pd_ni = 1'b0; ce_ni = 1'b0; oe_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R4 pd hiz", {16'h0, adq_oe_o}, 17'h0);
    pd_ni = 1'b1; idle();
    model_pd();

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      int unsigned op;
      logic [15:0] a;
      op = $urandom % 8;
      a  = 16'($urandom);
      if (op < 3) begin
        if (m_ident) a[7:0] = 8'($urandom % 4);
        chk_read(m_ident ? "R7 random ident" : "R2 random array", a);
      end else if (op == 3) begin
        write_cmd(a, ($urandom % 2) ? 16'h0090 : 16'h00FF, 1'b0);
      end else if (op < 6) begin
        write_cmd(a, 16'h0041 + 16'($urandom % 3), 1'b0);
      end else if (op == 6) begin
        @(negedge clk);
        wp_ni = 1'($urandom);
      end else if (($urandom % 4) == 0) begin
        write_cmd(a, 16'h0042, 1'b1);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule